// File: doc/BRIEF.md
# Bounded Range Select with Max Accumulator

This block takes one row of single-precision values at a time, one value per clock beat. Each value has a position: the row's start offset plus the value's column index within the row. Two comparisons test that position, each against its own per-row bound and each with its own operator. When both comparisons pass, the input value goes straight to the output. When either fails, the output is the most negative finite single-precision number, called the fill value. The output appears one clock after the input.

A command given with the first beat of a row controls a running-maximum register. The command can clear the register, fold the row's outputs into it, do both, or leave it alone. The register keeps its value across rows, so a single maximum can be built up over several rows. The command that loads an outside value is not accepted by this block and raises an error flag. Software or a sequencer holds the bounds, the operator selects, the start offset and the command stable for the whole row and marks the row's last beat.

Top module: `rangeSelAcc`

## Requirements
- R1: After reset, outValid is 0, accMax is 32'hFF7FFFFF (the fill value) and cmdErr is 0.
- R2: The position of a beat is startPos plus its column index. The column index is 0 on the first valid beat after reset or after a beat with inLast high, and goes up by one on each valid beat after that.
- R3: Each operator select compares the position (as left operand) with its bound: 0 equal, 1 less, 2 less-or-equal, 3 greater, 4 greater-or-equal. Codes 5 to 7 never pass.
- R4: One cycle after a valid beat, outValid is 1 and outData is inData when both comparisons pass, else 32'hFF7FFFFF. With no beat, outValid is 0 in the next cycle.
- R5: accCmd is sampled on the first beat of a row and applies to the whole row, with the codes idle=0, reset=1, reduce=2, reset_reduce=3, load_reduce=4.
- R6: reset sets accMax to the fill value and does not fold the row's outputs.
- R7: reduce sets accMax to the maximum of its old value and every output of the row.
- R8: reset_reduce sets accMax to the maximum of the row's outputs.
- R9: idle leaves accMax unchanged.
- R10: A command of 4 or higher is rejected. cmdErr goes to 1 in the cycle after that row's first beat and stays at 1 until the next row with a legal command. accMax does not change during the rejected row.
- R11: Positions are exact up to 2^24-1. A row whose start offset is near 2^24 selects exactly the positions its bounds name.
- R12: Both the maximum and the bound comparisons follow true numeric order for negative values as well as positive ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat is valid |
| inLast | input | 1 | Valid beat is the last of its row |
| inData | input | 32 | Single-precision input value |
| startPos | input | POS_W | Row start offset |
| bound0 | input | 32 | First bound, single precision |
| bound1 | input | 32 | Second bound, single precision |
| cmpSel0 | input | 3 | Operator for bound0 |
| cmpSel1 | input | 3 | Operator for bound1 |
| accCmd | input | 3 | Accumulator command, sampled on the first beat |
| outValid | output | 1 | Output beat is valid |
| outData | output | 32 | Selected value or fill value |
| accMax | output | 32 | Running maximum register |
| cmdErr | output | 1 | Current row's command was rejected |

## Verification
The assertions assume that no input is NaN or negative zero. They also assume that startPos plus the row length stays below 2^POS_W, and that row settings do not change in the middle of a row. The stimulus builds every data value and bound from multiples of a quarter converted exactly to single precision, and it never produces zero with a sign bit. It applies row settings only at row boundaries. The sweep covers every pair of operator codes, including the three unused codes, around a fixed pair of bounds. One row sits just below the 2^24 position limit.

// File: rtl/rsPkg.sv
package rsPkg;

  localparam logic [31:0] FILL_F32 = 32'hFF7FFFFF;

  typedef enum logic [2:0] {
    ACC_IDLE        = 3'd0,
    ACC_RESET       = 3'd1,
    ACC_REDUCE      = 3'd2,
    ACC_RESET_RED   = 3'd3,
    ACC_LOAD_RED    = 3'd4
  } accCmd_e;

  typedef enum logic [2:0] {
    CMP_EQ = 3'd0,
    CMP_LT = 3'd1,
    CMP_LE = 3'd2,
    CMP_GT = 3'd3,
    CMP_GE = 3'd4
  } cmpOp_e;

  // strobes from control to datapath for one beat
  typedef struct packed {
    logic beat;
    logic resetAcc;
    logic foldEn;
  } strobe_t;

  // map a float bit pattern to an unsigned key with the same order
  function automatic logic [31:0] ordKey(input logic [31:0] f);
    return f[31] ? ~f : (f ^ 32'h80000000);
  endfunction

  function automatic logic cmpHit(input logic [2:0] op, input logic [31:0] a,
                                  input logic [31:0] b);
    logic r;
    case (op)
      CMP_EQ:  r = (a == b);
      CMP_LT:  r = (a < b);
      CMP_LE:  r = (a <= b);
      CMP_GT:  r = (a > b);
      CMP_GE:  r = (a >= b);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rsPosConv.sv
module rsPosConv #(
  parameter int POS_W = 24
) (
  input  logic [POS_W-1:0] pos,
  output logic [31:0]      posF
);
  localparam int SIG_W = 24;

  logic [4:0]       msb;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] norm;

  always_comb begin
    msb = '0;
    for (int b = 0; b < POS_W; b++) begin
      if (pos[b]) msb = 5'(b);
    end
    sig  = SIG_W'(pos);
    norm = sig << (5'(SIG_W - 1) - msb);
    if (pos == '0) posF = 32'h0;
    else           posF = {1'b0, 8'(8'd127 + 8'(msb)), norm[SIG_W-2:0]};
  end
endmodule

// File: rtl/rsCtrl.sv
module rsCtrl #(
  parameter int POS_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inLast,
  input  logic [2:0]          accCmd,
  output logic [POS_W-1:0]    colIdx,
  output rsPkg::strobe_t      strb,
  output logic                cmdErr
);
  import rsPkg::*;

  logic [POS_W-1:0] colCnt;
  logic             midRow;
  logic [2:0]       rowCmd;
  logic [2:0]       curCmd;
  logic             legal;
  logic             firstBeat;

  assign colIdx    = colCnt;
  assign firstBeat = inValid && !midRow;
  assign curCmd    = midRow ? rowCmd : accCmd;
  assign legal     = (curCmd <= 3'(ACC_RESET_RED));

  always_comb begin
    strb.beat     = inValid;
    strb.resetAcc = firstBeat && legal &&
                    (curCmd == 3'(ACC_RESET) || curCmd == 3'(ACC_RESET_RED));
    strb.foldEn   = inValid && legal &&
                    (curCmd == 3'(ACC_REDUCE) || curCmd == 3'(ACC_RESET_RED));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      midRow <= 1'b0;
      rowCmd <= 3'(ACC_IDLE);
      cmdErr <= 1'b0;
    end else if (inValid) begin
      if (firstBeat) begin
        rowCmd <= accCmd;
        cmdErr <= !legal;
      end
      if (inLast) begin
        colCnt <= '0;
        midRow <= 1'b0;
      end else begin
        colCnt <= colCnt + 1'b1;
        midRow <= 1'b1;
      end
    end
  end

  // R10
  cmd_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !midRow && accCmd > 3'(ACC_RESET_RED)) |=> cmdErr);

  // R2
  col_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> (colIdx == '0));
endmodule

// File: rtl/rsDatapath.sv
module rsDatapath #(
  parameter int POS_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  rsPkg::strobe_t     strb,
  input  logic [31:0]        inData,
  input  logic [POS_W-1:0]   startPos,
  input  logic [POS_W-1:0]   colIdx,
  input  logic [31:0]        bound0,
  input  logic [31:0]        bound1,
  input  logic [2:0]         cmpSel0,
  input  logic [2:0]         cmpSel1,
  output logic               outValid,
  output logic [31:0]        outData,
  output logic [31:0]        accMax
);
  import rsPkg::*;

  localparam int NUM_BND = 2;

  logic [POS_W-1:0] pos;
  logic [31:0]      posF;
  logic [31:0]      posKey;
  logic [31:0]      bnd [NUM_BND];
  logic [2:0]       sel [NUM_BND];
  logic [NUM_BND-1:0] hit;
  logic [31:0]      selVal;
  logic [31:0]      accBase;
  logic [31:0]      accNext;

  assign pos    = startPos + colIdx;
  assign bnd[0] = bound0;
  assign bnd[1] = bound1;
  assign sel[0] = cmpSel0;
  assign sel[1] = cmpSel1;

  rsPosConv #(.POS_W(POS_W)) uConv (.pos(pos), .posF(posF));

  assign posKey = ordKey(posF);

  for (genvar g = 0; g < NUM_BND; g++) begin : gCmp
    assign hit[g] = cmpHit(sel[g], posKey, ordKey(bnd[g]));
  end

  assign selVal  = (&hit) ? inData : FILL_F32;
  assign accBase = strb.resetAcc ? FILL_F32 : accMax;
  assign accNext = (ordKey(selVal) > ordKey(accBase)) ? selVal : accBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      accMax   <= FILL_F32;
    end else begin
      outValid <= strb.beat;
      if (strb.beat) outData <= selVal;
      if (strb.foldEn)        accMax <= accNext;
      else if (strb.resetAcc) accMax <= FILL_F32;
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |=> outValid);

  // R4
  sel_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beat |=> (outData == FILL_F32 || outData == $past(inData)));

  // R6
  reset_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resetAcc && !strb.foldEn) |=> (accMax == FILL_F32));

  // R7
  acc_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.foldEn && !strb.resetAcc) |=> (ordKey(accMax) >= ordKey($past(accMax))));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.resetAcc && !strb.foldEn) |=> $stable(accMax));
endmodule

// File: rtl/rangeSelAcc.sv
module rangeSelAcc #(
  parameter int POS_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [31:0]      inData,
  input  logic [POS_W-1:0] startPos,
  input  logic [31:0]      bound0,
  input  logic [31:0]      bound1,
  input  logic [2:0]       cmpSel0,
  input  logic [2:0]       cmpSel1,
  input  logic [2:0]       accCmd,
  output logic             outValid,
  output logic [31:0]      outData,
  output logic [31:0]      accMax,
  output logic             cmdErr
);
  rsPkg::strobe_t   strb;
  logic [POS_W-1:0] colIdx;

  rsCtrl #(.POS_W(POS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .accCmd(accCmd), .colIdx(colIdx), .strb(strb), .cmdErr(cmdErr)
  );

  rsDatapath #(.POS_W(POS_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .startPos(startPos), .colIdx(colIdx), .bound0(bound0), .bound1(bound1),
    .cmpSel0(cmpSel0), .cmpSel1(cmpSel1), .outValid(outValid),
    .outData(outData), .accMax(accMax)
  );
endmodule

// File: tb/sim_rangeSelAcc.sv
`timescale 1ns/1ps
module sim_rangeSelAcc;
  localparam int POS_W = 24;
  localparam real FILL_R = -3.4028234663852886e38;

  logic clk = 0, rstN = 0, inValid = 0, inLast = 0;
  logic [31:0] inData = 0, bound0 = 0, bound1 = 0;
  logic [POS_W-1:0] startPos = 0;
  logic [2:0] cmpSel0 = 0, cmpSel1 = 0, accCmd = 0;
  logic outValid, cmdErr;
  logic [31:0] outData, accMax;

  int errors = 0, checks = 0;
  bit done = 0;
  real accExp;

  always #10 clk = ~clk;

  rangeSelAcc #(.POS_W(POS_W)) u0 (.*);

  function automatic logic [31:0] toF32(input real r);
    logic [63:0] b;
    if (r == 0.0) return 32'h0;
    b = $realtobits(r);
    return {b[63], 8'(int'(b[62:52]) - 1023 + 127), b[51:29]};
  endfunction

  function automatic bit cmpR(input int op, input real a, input real b);
    case (op)
      0: return a == b;
      1: return a < b;
      2: return a <= b;
      3: return a > b;
      4: return a >= b;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runRow(input int start, input real b0, input real b1,
                        input int op0, input int op1, input int cmd, input int len,
                        input real base, input real step, input string req);
    real d, sel;
    bit legal;
    legal = (cmd <= 3);
    if (legal && (cmd == 1 || cmd == 3)) accExp = FILL_R;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      d = base + step * i;
      inValid = 1; inLast = (i == len - 1); inData = toF32(d);
      startPos = POS_W'(start); bound0 = toF32(b0); bound1 = toF32(b1);
      cmpSel0 = 3'(op0); cmpSel1 = 3'(op1); accCmd = 3'(cmd);
      @(posedge clk); #1;
      // R2 R3 R4: position start+i tested against both bounds
      sel = (cmpR(op0, real'(start + i), b0) && cmpR(op1, real'(start + i), b1)) ? d : FILL_R;
      check({req, " R4 outValid"}, {31'b0, outValid}, 32'd1);
      check({req, " R3 outData"}, outData, toF32(sel));
      if (legal && (cmd == 2 || cmd == 3) && sel > accExp) accExp = sel;
      // R10: error flag raised after first beat of a rejected row
      check({req, " R10 cmdErr"}, {31'b0, cmdErr}, {31'b0, !legal});
    end
    @(negedge clk);
    inValid = 0; inLast = 0;
    check({req, " R5 accMax"}, accMax, toF32(accExp));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    accExp = FILL_R;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 accMax", accMax, 32'hFF7FFFFF);
    check("R1 cmdErr", {31'b0, cmdErr}, 32'd0);
    rstN = 1;
    // R3 R4 R8: every operator pair, reset_reduce each row
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        runRow(3, 6.0, 8.5, a, b, 3, 8, -7.0 + a * 0.5, 2.25, "R8 sweep");
    // R6 reset then R7 reduce across rows
    runRow(0, 0.0, 100.0, 4, 1, 1, 4, 50.0, 1.0, "R6 reset");
    runRow(0, 1.0, 3.0, 4, 2, 2, 5, -2.0, 1.5, "R7 reduce a");
    runRow(10, 0.0, 100.0, 4, 1, 2, 4, -9.0, -0.25, "R7 reduce b");
    // R9 idle leaves accumulator
    runRow(0, 0.0, 100.0, 4, 1, 0, 4, 900.0, 1.0, "R9 idle");
    // R10 load_reduce and unused code rejected
    runRow(0, 0.0, 100.0, 4, 1, 4, 3, 800.0, 1.0, "R10 load");
    runRow(0, 0.0, 100.0, 4, 1, 7, 2, 800.0, 1.0, "R10 code7");
    runRow(0, 0.0, 100.0, 4, 1, 2, 2, 0.5, 0.25, "R10 recover");
    // R11 positions near 2^24
    runRow(16777208, 16777211.0, 16777214.0, 4, 1, 3, 8, 1.0, 1.0, "R11 large");
    // R12 negative values and negative bounds
    runRow(0, -1.0, 5.0, 3, 1, 3, 8, -20.0, 1.75, "R12 neg");
    runRow(0, 2.0, 2.0, 4, 2, 3, 6, -0.25, -3.0, "R12 negmax");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule